// File: doc/BRIEF.md
# Four-Digit Seven-Segment Scan Driver

This block shows a 16-bit value as four hexadecimal digits on a common-anode seven-segment display. The digits share one set of segment lines, so the driver turns on one digit position at a time. It steps through the positions fast enough that the eye sees all four digits lit at once. A prescaler inside the block divides the system clock down to the scan rate. On each scan tick the selector moves to the next digit position. The selected nibble is decoded into a segment pattern. The anode line and the segment lines are both active-low.

The value input is a plain level input with no handshake. The block samples it on every clock and never stalls it. A new value therefore shows up on the lit digit one clock later. The decimal point is not used and is held dark. The scan rate is a parameter. It is checked when the design is elaborated and must lie inside the allowed refresh window.

Top module: `seg_mux4_drv`

## Requirements
- R1: While reset is high, and after reset is released, every anode line, every segment line and the decimal-point line read 1 (dark) until the first scan tick has been registered. The scan then starts again from digit position 0.
- R2: At most one bit of `an_n` is 0 in any cycle.
- R3: Digit positions are lit in the order 0, 1, 2, 3 and then wrap back to 0. When position k is lit, `an_n[k]` is 0 and the segments show the nibble `value[4k+3:4k]`.
- R4: With DIV = CLK_HZ / SCAN_HZ, each position stays lit for exactly DIV clock cycles. Position 0 first lights at the (DIV+1)-th rising edge after reset is released.
- R5: The segment output is `seg_n[6:0]`. Bit 0 drives segment a, bits 1 to 5 drive segments b to f, and bit 6 drives segment g. A 0 lights a segment. The glyphs, written active-high as {g..a}, are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71.
- R6: `dp_n` is 1 in every cycle.
- R7: A change on `value` appears on the lit digit's segments one rising edge after the change. The anode scan timing does not change.
- R8: SCAN_HZ must lie between 60 and 1000, and DIV must be at least 2. Any other setting stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| value | input | 16 | Four hex digits; digit k is value[4k+3:4k] |
| an_n | output | 4 | Anode selects, active-low, one per digit position |
| seg_n | output | 7 | Segment lines a..g, active-low |
| dp_n | output | 1 | Decimal point, active-low, held off |

## Verification
The scan is driven with a set of values chosen to tell faults apart. Some place every hex glyph once, in ascending order across the positions, so a swap of positions or a wrong decode of any nibble shows up. Others are all-equal (0000, FFFF), so a fault in the anode scan cannot be hidden by identical glyphs. Mixed values such as A5C3 and 1E0D set every position to a different glyph, which catches errors in nibble slicing. The value is changed while a digit is lit, to confirm the one-edge update. A reset in the middle of a scan confirms that the display goes dark and that the scan restarts at position 0 with the timing in R4.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  // Active-high glyph, bit order {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] glyph_hi(input logic [DIGIT_W-1:0] nib);
    logic [SEG_W-1:0] g;
    case (nib)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/seg_scan_tick.sv
module seg_scan_tick #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/seg_digit_sel.sv
module seg_digit_sel #(
  parameter int NUM_DIGITS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  output logic [$clog2(NUM_DIGITS)-1:0] sel,
  output logic                          active
);
  localparam int SEL_W = $clog2(NUM_DIGITS);
  localparam logic [SEL_W-1:0] TOP = SEL_W'(NUM_DIGITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= '0;
      active <= 1'b0;
    end else if (tick) begin
      if (!active)        active <= 1'b1;
      else if (sel == TOP) sel   <= '0;
      else                 sel   <= sel + 1'b1;
    end
  end

  // R3
  sel_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && active) |=> (sel == (($past(sel) == TOP) ? '0 : $past(sel) + 1'b1)));

  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(sel) && $stable(active)));

  // R1
  first_digit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> (sel == '0));
endmodule

// File: rtl/seg_hex_glyph.sv
module seg_hex_glyph
  import seg_drv_pkg::*;
(
  input  logic [DIGIT_W-1:0] nib,
  input  logic               lit,
  output logic [SEG_W-1:0]   seg_n
);
  always_comb begin
    if (lit) seg_n = ~glyph_hi(nib);
    else     seg_n = '1;
  end
endmodule

// File: rtl/seg_mux4_drv.sv
module seg_mux4_drv
  import seg_drv_pkg::*;
#(
  parameter int CLK_HZ     = 50000000,
  parameter int SCAN_HZ    = 1000,
  parameter int NUM_DIGITS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] value,
  output logic [NUM_DIGITS-1:0]         an_n,
  output logic [SEG_W-1:0]              seg_n,
  output logic                          dp_n
);
  localparam int DIV   = CLK_HZ / SCAN_HZ;
  localparam int SEL_W = $clog2(NUM_DIGITS);

  // R8
  generate
    if (SCAN_HZ < 60 || SCAN_HZ > 1000) begin : g_rate_bad
      $error("scan rate outside 60..1000 Hz window");
    end
    if (DIV < 2) begin : g_div_bad
      $error("clock too slow for requested scan rate");
    end
  endgenerate

  logic             tick;
  logic [SEL_W-1:0] sel;
  logic             active;
  logic [DIGIT_W-1:0] nibs [NUM_DIGITS];
  logic [DIGIT_W-1:0] cur_nib;
  logic [NUM_DIGITS-1:0] an_next;
  logic [SEG_W-1:0] seg_next;

  seg_scan_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  seg_digit_sel #(.NUM_DIGITS(NUM_DIGITS)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .sel    (sel),
    .active (active)
  );

  generate
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
      assign nibs[k]    = value[k*DIGIT_W +: DIGIT_W];
      assign an_next[k] = !(active && (sel == SEL_W'(k)));
    end
  endgenerate

  assign cur_nib = nibs[sel];

  seg_hex_glyph u_glyph (
    .nib   (cur_nib),
    .lit   (active),
    .seg_n (seg_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      an_n  <= '1;
      seg_n <= '1;
    end else begin
      an_n  <= an_next;
      seg_n <= seg_next;
    end
  end

  assign dp_n = 1'b1;

  // R2
  one_anode_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~an_n));

  // R1
  reset_dark_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((an_n == '1) && (seg_n == '1)));

  // R3
  anode_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(~an_n) == 1 && !$stable(an_n)) |-> ($countones(~$past(an_n)) <= 1));
endmodule

// File: tb/tb_seg_mux4_drv.sv
module tb_seg_mux4_drv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] value = 16'h0000;
  logic [3:0]  an_n;
  logic [6:0]  seg_n;
  logic        dp_n;

  int checks = 0;
  int fails  = 0;
  int e      = 0;
  bit done   = 1'b0;

  // DIV = 4 clock cycles per digit position
  seg_mux4_drv #(.CLK_HZ(4000), .SCAN_HZ(1000), .NUM_DIGITS(4)) dut (
    .clk   (clk),
    .rst   (rst),
    .value (value),
    .an_n  (an_n),
    .seg_n (seg_n),
    .dp_n  (dp_n)
  );

  always #2 clk = ~clk;

  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{16'h3210, 16'h7654, 16'hBA98, 16'hFEDC,
                                       16'hFFFF, 16'h0000, 16'hA5C3, 16'h1E0D};

  function automatic logic [6:0] hex_hi(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  function automatic int digit_at(input int edge_no);
    return ((edge_no - 5) / 4) % 4;
  endfunction

  function automatic logic [3:0] exp_an(input int edge_no);
    if (edge_no < 5) return 4'hF;
    return ~(4'b0001 << digit_at(edge_no));
  endfunction

  function automatic logic [6:0] exp_seg(input int edge_no, input logic [15:0] v);
    if (edge_no < 5) return 7'h7F;
    return ~hex_hi(v[digit_at(edge_no)*4 +: 4]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, e);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    e++;
  endtask

  task automatic check_cycle(input string seg_req);
    logic [3:0] ea;
    logic [6:0] es;
    ea = exp_an(e);
    es = exp_seg(e, value);
    chk(an_n == ea, "R3/R4 anode", int'(an_n), int'(ea));
    chk(seg_n == es, seg_req, int'(seg_n), int'(es));
    chk($countones(~an_n) <= 1, "R2 one anode", int'(an_n), 0);
    chk(dp_n == 1'b1, "R6 dp off", int'(dp_n), 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: dark while in reset
    chk(an_n == 4'hF, "R1 anode in reset", int'(an_n), 15);
    chk(seg_n == 7'h7F, "R1 segs in reset", int'(seg_n), 127);
    rst = 1'b0;
    e = 0;
    // R1 R4: dark for DIV edges, position 0 at edge DIV+1
    for (int i = 0; i < 4; i++) begin
      step();
      chk(an_n == 4'hF, "R1 dark after release", int'(an_n), 15);
      chk(seg_n == 7'h7F, "R1 segs dark", int'(seg_n), 127);
    end

    // Table walk: R3 R5 R7
    for (int v = 0; v < NV; v++) begin
      value = VEC[v];
      step();
      check_cycle("R7 new value on segs");
      for (int c = 0; c < 15; c++) begin
        step();
        check_cycle("R5 glyph");
      end
    end

    // R7: change mid-digit
    value = 16'h8421;
    repeat (2) step();
    value = 16'h2481;
    step();
    check_cycle("R7 mid-digit change");

    // R1: reset mid-scan, restart at position 0
    rst = 1'b1;
    step();
    chk(an_n == 4'hF, "R1 mid-scan reset anode", int'(an_n), 15);
    chk(seg_n == 7'h7F, "R1 mid-scan reset segs", int'(seg_n), 127);
    rst = 1'b0;
    e = 0;
    value = 16'hC0DE;
    for (int c = 0; c < 24; c++) begin
      step();
      check_cycle("R5 glyph after reset");
    end
    // R4: position 0 at edge 5 confirmed above; explicit wrap check R3
    chk(digit_at(e) == 0 || an_n != 4'hE, "R3 wrap", int'(an_n), 14);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule